// File: doc/BRIEF.md
# Four-Lane PRBS Loopback Test Controller

This block drives a loopback test across four parallel serial-link lanes. Each transmit lane carries its own pseudo-random word stream. The receive side takes back the same four lanes, after external word alignment and lane bonding, and checks every word against a receive-side generator that locks onto the incoming stream. The serializer, the line coding and the alignment and bonding circuits themselves sit outside this block. The block only drives their enable strobes and reads back a bonded flag.

An operator brings the link up in three steps, using three pushbuttons. The first button turns on comma detection and word alignment. The second turns on lane bonding. The third starts traffic. A step only takes effect once the step before it is active. Four LEDs show the three stages and a sticky error flag. If the second and third buttons are released together, one bit of a single transmit word is flipped on purpose. This confirms that the checker reports the fault.

Top module: `prbs_loop_ctl`

## Requirements
- R1: While reset is high, and after it falls, every LED is off, both enable outputs are low, `tx_valid_o` is low and `tx_data_o` is all zeros.
- R2: A debounced release of `btn_i[0]` while everything is disabled raises `align_en_o` and LED0 (`leds_o[0]`). Further releases of it change nothing.
- R3: A lone release of `btn_i[1]` raises `bond_en_o` and LED1 only when alignment is already enabled. Before that it is ignored.
- R4: A lone release of `btn_i[2]` starts traffic only when bonding is already enabled. Traffic start means LED2 on and `tx_valid_o` high with a new word every cycle. Before that the release is ignored.
- R5: Each lane steps a 31-bit state through 32 iterations of new = s[30] XOR s[27], s = {s[29:0], new} per word. Bit 31 of the word is the oldest of the 32 new bits and bit 0 is the newest. Lane i (bits i*32 and up) starts from state SEED_BASE + i.
- R6: The four lanes carry different words, and each lane advances once per cycle while traffic runs.
- R7: The receive generator of each lane loads its state from bits 30:0 of the first accepted word after traffic starts. From then on it advances every cycle and compares every accepted word. A clean loopback never lights LED3.
- R8: A mismatch on any lane lights LED3 (`leds_o[3]`). It stays lit until reset.
- R9: A word is accepted only when both `rx_valid_i` and `rx_bonded_i` are high. Other words never raise an error, whatever their content.
- R10: Releases of buttons 1 and 2 that fall within one debounce window form a combined press. During traffic this flips bit 0 of lane 0 in exactly one transmit word and leaves the stages unchanged.
- R11: A button level held for fewer cycles than DB_CNT is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 3 | Raw pushbutton levels, high while pressed |
| tx_data_o | output | LANES*32 | Transmit words, lane i in bits i*32+31:i*32 |
| tx_valid_o | output | 1 | High while traffic runs |
| align_en_o | output | 1 | Comma detect / word align enable |
| bond_en_o | output | 1 | Lane bonding enable |
| rx_data_i | input | LANES*32 | Received bonded words, same lane layout |
| rx_valid_i | input | 1 | Received word valid |
| rx_bonded_i | input | 1 | External bonding logic reports lanes bonded |
| leds_o | output | 4 | Align, bond, traffic, sticky error |

## Verification
The bench presses buttons out of order, and each stage must stay dark until its predecessor is lit. A design that skipped the gating would light LED1 or LED2 early.

A three-cycle glitch is applied to test debouncing; a design that acted on raw levels would change stage on it. Corrupted words are fed in with the valid flag low, and separately with the bonded flag low. A checker that compared them, or that stalled its generator while they passed, would light LED3.

The injection test counts how many transmit words and bits depart from an independent model. A design that flipped for several cycles, flipped a different lane, or treated the paired release as two separate presses shows up in those counts.

// File: rtl/prbs_loop_pkg.sv
package prbs_loop_pkg;

    localparam int WORD_W  = 32;
    localparam int STATE_W = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_BOND  = 2'd2,
        ST_RUN   = 2'd3
    } stage_e;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [WORD_W-1:0]  word;
    } prbs_step_t;

    // x^31 + x^28 + 1, WORD_W bits per call, oldest bit lands in the MSB
    function automatic prbs_step_t prbs31_advance(input logic [STATE_W-1:0] s_in);
        prbs_step_t r;
        logic [STATE_W-1:0] s;
        logic [WORD_W-1:0]  w;
        logic nb;
        s = s_in;
        w = '0;
        for (int i = 0; i < WORD_W; i++) begin
            nb = s[30] ^ s[27];
            s  = {s[STATE_W-2:0], nb};
            w  = {w[WORD_W-2:0], nb};
        end
        r.state = s;
        r.word  = w;
        return r;
    endfunction

endpackage

// File: rtl/btn_cond.sv
module btn_cond #(
    parameter int DB_CNT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rel_o
);
    localparam int CW = $clog2(DB_CNT + 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            rel_o    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            rel_o  <= 1'b0;
            if (sync_q[1] == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DB_CNT - 1)) begin
                stable_q <= sync_q[1];
                cnt_q    <= '0;
                rel_o    <= stable_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/prbs_tx_lane.sv
module prbs_tx_lane
    import prbs_loop_pkg::*;
#(
    parameter logic [STATE_W-1:0] SEED = 31'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              flip_i,
    output logic [WORD_W-1:0] word_o
);
    logic [STATE_W-1:0] state_q;
    prbs_step_t         nxt;

    always_comb nxt = prbs31_advance(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
            word_o  <= '0;
        end else if (run_i) begin
            state_q <= nxt.state;
            word_o  <= nxt.word ^ {{(WORD_W-1){1'b0}}, flip_i};
        end
    end
endmodule

// File: rtl/prbs_rx_lane.sv
module prbs_rx_lane
    import prbs_loop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              ok_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              mism_o
);
    logic               seeded_q;
    logic [STATE_W-1:0] state_q;
    prbs_step_t         nxt;

    always_comb nxt = prbs31_advance(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            seeded_q <= 1'b0;
            state_q  <= '0;
            mism_o   <= 1'b0;
        end else begin
            mism_o <= 1'b0;
            if (arm_i) begin
                if (!seeded_q) begin
                    if (ok_i) begin
                        state_q  <= word_i[STATE_W-1:0];
                        seeded_q <= 1'b1;
                    end
                end else begin
                    state_q <= nxt.state;
                    if (ok_i && (word_i != nxt.word))
                        mism_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prbs_loop_ctl.sv
module prbs_loop_ctl
    import prbs_loop_pkg::*;
#(
    parameter int                 LANES     = 4,
    parameter int                 DB_CNT    = 1000,
    parameter logic [STATE_W-1:0] SEED_BASE = 31'h2A5F_0C31
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                btn_i,
    output logic [LANES*WORD_W-1:0]   tx_data_o,
    output logic                      tx_valid_o,
    output logic                      align_en_o,
    output logic                      bond_en_o,
    input  logic [LANES*WORD_W-1:0]   rx_data_i,
    input  logic                      rx_valid_i,
    input  logic                      rx_bonded_i,
    output logic [3:0]                leds_o
);
    localparam int NBTN = 3;
    localparam int WCW  = $clog2(DB_CNT + 1);

    logic [NBTN-1:0] rel;

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        btn_cond #(.DB_CNT(DB_CNT)) u_btn (
            .clk   (clk),
            .rst   (rst),
            .raw_i (btn_i[b]),
            .rel_o (rel[b])
        );
    end

    // Pairing window for buttons 1 and 2
    logic           win_on;
    logic [1:0]     win_mask;
    logic [WCW-1:0] win_cnt;
    logic           fire;
    logic [1:0]     fire_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_on    <= 1'b0;
            win_mask  <= '0;
            win_cnt   <= '0;
            fire      <= 1'b0;
            fire_mask <= '0;
        end else begin
            fire <= 1'b0;
            if (win_on) begin
                win_mask <= win_mask | rel[2:1];
                if (win_cnt == WCW'(DB_CNT - 1)) begin
                    win_on    <= 1'b0;
                    fire      <= 1'b1;
                    fire_mask <= win_mask | rel[2:1];
                end else begin
                    win_cnt <= win_cnt + 1'b1;
                end
            end else if (|rel[2:1]) begin
                win_on   <= 1'b1;
                win_mask <= rel[2:1];
                win_cnt  <= '0;
            end
        end
    end

    logic ev_bond, ev_start, ev_pair;
    assign ev_bond  = fire && (fire_mask == 2'b01);
    assign ev_start = fire && (fire_mask == 2'b10);
    assign ev_pair  = fire && (fire_mask == 2'b11);

    stage_e stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_IDLE;
        end else begin
            unique case (stage_q)
                ST_IDLE:  if (rel[0])   stage_q <= ST_ALIGN;
                ST_ALIGN: if (ev_bond)  stage_q <= ST_BOND;
                ST_BOND:  if (ev_start) stage_q <= ST_RUN;
                default:  stage_q <= stage_q;
            endcase
        end
    end

    logic run, inject;
    assign run    = (stage_q == ST_RUN);
    assign inject = ev_pair && run;

    logic [LANES-1:0] flip_vec;
    logic [LANES-1:0] mism_vec;
    logic             rx_ok;
    assign flip_vec = {{(LANES-1){1'b0}}, inject};
    assign rx_ok    = rx_valid_i & rx_bonded_i;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        prbs_tx_lane #(.SEED(SEED_BASE + STATE_W'(l))) u_tx (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run),
            .flip_i (flip_vec[l]),
            .word_o (tx_data_o[l*WORD_W +: WORD_W])
        );
        prbs_rx_lane u_rx (
            .clk    (clk),
            .rst    (rst),
            .arm_i  (run),
            .ok_i   (rx_ok),
            .word_i (rx_data_i[l*WORD_W +: WORD_W]),
            .mism_o (mism_vec[l])
        );
    end

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q      <= 1'b0;
            tx_valid_o <= 1'b0;
        end else begin
            tx_valid_o <= run;
            if (|mism_vec) err_q <= 1'b1;
        end
    end

    assign align_en_o = (stage_q != ST_IDLE);
    assign bond_en_o  = (stage_q == ST_BOND) || run;
    assign leds_o     = {err_q, run, bond_en_o, align_en_o};

endmodule

// File: rtl/prbs_loop_chk.sv
module prbs_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] leds,
    input logic       align_en,
    input logic       bond_en,
    input logic       tx_valid
);
    // R3
    bond_needs_align_chk: assert property (@(posedge clk) disable iff (rst)
        bond_en |-> align_en);

    // R4
    traffic_needs_bond_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> bond_en);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        leds[3] |=> leds[3]);

    // R8
    err_only_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        leds[3] |-> leds[2]);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (leds == 4'b0000) && !tx_valid && !align_en && !bond_en);
endmodule

bind prbs_loop_ctl prbs_loop_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .leds     (leds_o),
    .align_en (align_en_o),
    .bond_en  (bond_en_o),
    .tx_valid (tx_valid_o)
);

// File: tb/sim_prbs_loop_ctl.sv
`timescale 1ns/1ps
module sim_prbs_loop_ctl;
    localparam int LANES = 4;
    localparam int W     = 32;
    localparam int DB    = 8;
    localparam logic [30:0] SEED_BASE = 31'h2A5F_0C31;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2:0]           btn = '0;
    logic [LANES*W-1:0]   tx_data, rx_data, corrupt = '0;
    logic                 tx_valid, align_en, bond_en;
    logic                 rx_en = 1'b1, bonded = 1'b1;
    logic [3:0]           leds;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    assign rx_data = tx_data ^ corrupt;

    prbs_loop_ctl #(.LANES(LANES), .DB_CNT(DB), .SEED_BASE(SEED_BASE)) u0 (
        .clk(clk), .rst(rst), .btn_i(btn), .tx_data_o(tx_data),
        .tx_valid_o(tx_valid), .align_en_o(align_en), .bond_en_o(bond_en),
        .rx_data_i(rx_data), .rx_valid_i(tx_valid & rx_en),
        .rx_bonded_i(bonded), .leds_o(leds)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-serial model: b[n] = b[n-31] ^ b[n-28]
    function automatic logic [62:0] bgen(input logic [30:0] s);
        logic [31:0] w;
        logic b;
        for (int i = 0; i < 32; i++) begin
            b = s[30] ^ s[27];
            s = {s[29:0], b};
            w[31-i] = b;
        end
        return {s, w};
    endfunction

    // transmit monitor against the independent model
    logic [30:0] m_st [LANES];
    bit mon_on = 0, first_ok = 0, distinct = 0;
    int bad_w [LANES];
    int flips = 0;
    initial for (int l = 0; l < LANES; l++) bad_w[l] = 0;

    always @(negedge clk) begin
        if (rst) begin
            mon_on = 0;
        end else if (tx_valid) begin
            logic [62:0] r;
            logic [31:0] tw;
            if (!mon_on) begin
                for (int l = 0; l < LANES; l++) m_st[l] = SEED_BASE + 31'(l);
                mon_on = 1;
                distinct = 1;
                for (int a = 0; a < LANES; a++)
                    for (int b = a + 1; b < LANES; b++)
                        if (tx_data[a*W +: W] == tx_data[b*W +: W]) distinct = 0;
                r = bgen(m_st[0]);
                first_ok = (tx_data[W-1:0] == r[31:0]);
            end
            for (int l = 0; l < LANES; l++) begin
                r = bgen(m_st[l]);
                m_st[l] = r[62:32];
                tw = tx_data[l*W +: W];
                if (tw != r[31:0]) begin
                    bad_w[l]++;
                    if (l == 0) flips += $countones(tw ^ r[31:0]);
                end
            end
        end
    end

    task automatic press(input logic [2:0] m);
        @(negedge clk); btn = m;
        repeat (DB + 6) @(negedge clk);
        btn = '0;
        repeat (3*DB + 10) @(negedge clk);
    endtask

    // {button mask, expected leds}
    localparam logic [6:0] VEC [7] = '{
        7'b100_0000, 7'b010_0000, 7'b001_0001, 7'b001_0001,
        7'b100_0001, 7'b010_0011, 7'b100_0111
    };

    initial begin
        fork
            begin
                #(4 * 150000);
                n_fail++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        repeat (5) @(negedge clk);
        // R1 reset state
        chk(leds == 4'b0 && !align_en && !bond_en && !tx_valid && tx_data == '0,
            "R1 reset state", {leds, align_en, bond_en, tx_valid}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(leds == 4'b0 && tx_data == '0, "R1 after reset", leds, 0);

        // R11 short glitch ignored
        btn = 3'b001;
        repeat (3) @(negedge clk);
        btn = '0;
        repeat (3*DB) @(negedge clk);
        chk(leds == 4'b0, "R11 glitch", leds, 0);

        // R2, R3, R4 stage gating table
        for (int i = 0; i < 7; i++) begin
            press(VEC[i][6:4]);
            chk(leds == VEC[i][3:0] && align_en == leds[0] && bond_en == leds[1],
                $sformatf("R2 R3 R4 row %0d", i), leds, VEC[i][3:0]);
        end
        chk(tx_valid == 1'b1, "R4 traffic valid", tx_valid, 1);

        repeat (50) @(negedge clk);
        chk(first_ok, "R5 first word from seed", first_ok, 1);
        chk(distinct, "R6 lanes distinct", distinct, 1);
        chk(bad_w[0] + bad_w[1] + bad_w[2] + bad_w[3] == 0, "R6 lanes advance",
            bad_w[0] + bad_w[1] + bad_w[2] + bad_w[3], 0);
        chk(leds == 4'b0111, "R7 clean loopback", leds, 4'b0111);

        // R9 invalid words ignored
        rx_en = 1'b0; corrupt = '1;
        repeat (20) @(negedge clk);
        rx_en = 1'b1; corrupt = '0;
        repeat (10) @(negedge clk);
        chk(leds == 4'b0111, "R9 valid low ignored", leds, 4'b0111);
        bonded = 1'b0; corrupt = '1;
        repeat (20) @(negedge clk);
        bonded = 1'b1; corrupt = '0;
        repeat (10) @(negedge clk);
        chk(leds == 4'b0111, "R9 unbonded ignored", leds, 4'b0111);

        // R10 combined press injects one flipped bit
        begin
            int b0, b1, b2, b3, f0;
            b0 = bad_w[0]; b1 = bad_w[1]; b2 = bad_w[2]; b3 = bad_w[3]; f0 = flips;
            @(negedge clk); btn = 3'b110;
            repeat (DB + 6) @(negedge clk);
            btn = 3'b100;
            repeat (3) @(negedge clk);
            btn = '0;
            repeat (3*DB + 10) @(negedge clk);
            chk(bad_w[0] - b0 == 1, "R10 one bad word lane 0", bad_w[0] - b0, 1);
            chk(flips - f0 == 1, "R10 one flipped bit", flips - f0, 1);
            chk((bad_w[1] - b1) + (bad_w[2] - b2) + (bad_w[3] - b3) == 0,
                "R10 other lanes clean", (bad_w[1] - b1) + (bad_w[2] - b2), 0);
            chk(leds == 4'b1111, "R8 R10 error lit, stages kept", leds, 4'b1111);
        end
        repeat (50) @(negedge clk);
        chk(leds[3] == 1'b1, "R8 sticky", leds[3], 1);

        // R1 reset clears the error
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(leds == 4'b0 && !tx_valid, "R1 R8 reset clears", leds, 0);

        // R8 receive-side mismatch on lane 2
        press(3'b001); press(3'b010); press(3'b100);
        repeat (20) @(negedge clk);
        chk(leds == 4'b0111, "R7 clean after restart", leds, 4'b0111);
        corrupt[2*W + 5] = 1'b1;
        @(negedge clk);
        corrupt = '0;
        repeat (5) @(negedge clk);
        chk(leds[3] == 1'b1, "R8 lane 2 mismatch", leds, 4'b1111);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule